// File: doc/BRIEF.md
# Retriggerable Edge-Qualified One-Shot Timer

This block is a clocked one-shot pulse generator. It watches three asynchronous control inputs. The first is a trigger that acts on its falling edge. The second is a trigger that acts on its rising edge. The third is an active-low clear. When a qualified edge arrives, the block drives a pulse output high for a programmable number of clock cycles and drives a complementary output with the opposite level. The pulse length comes from a width input, which takes the place of an analog timing network.

A qualified edge that arrives while the pulse is active reloads the interval. The pulse therefore ends one full width after the last such edge. Holding clear low ends any pulse at once and blocks every trigger. When clear is released with the falling-edge input low and the rising-edge input high, the release itself fires a pulse. After a clear, the two edge triggers stay locked out for a recovery window. The release-of-clear trigger is not affected by this window.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, with the inputs idle (falling-edge input high, rising-edge input low, clear high), `pulseOut` is 0 and `pulseOutN` is 1.
- R2: A falling edge on `trigFallIn`, while `trigRiseIn` and `clearNIn` are high, fires a pulse. `pulseOut` is high for exactly `widthCfg` cycles.
- R3: A rising edge on `trigRiseIn`, while `trigFallIn` is low and `clearNIn` is high, fires a pulse of `widthCfg` cycles.
- R4: An edge on either trigger input has no effect when the other trigger input is not at its qualifying level (`trigRiseIn` high for a falling edge, `trigFallIn` low for a rising edge).
- R5: A qualified edge that arrives while `pulseOut` is high restarts the interval. `pulseOut` falls `widthCfg` cycles after the pulse rise caused by the last such edge.
- R6: Driving `clearNIn` low during a pulse forces `pulseOut` low 3 clock cycles after the input change, even if the programmed width has not elapsed.
- R7: While `clearNIn` is low, edges on the trigger inputs are ignored. `pulseOut` stays 0.
- R8: A rising edge on `clearNIn`, while `trigFallIn` is low and `trigRiseIn` is high, fires a pulse. The recovery lockout does not apply to this trigger.
- R9: For RECOVER_CYCLES cycles after the synchronized clear returns high, edges on the two trigger inputs are ignored. Once that window has passed, they are accepted again.
- R10: A `widthCfg` of 0 produces a pulse of one cycle, the same as a width of 1.
- R11: `pulseOutN` is always the complement of `pulseOut`.
- R12: `pulseOut` rises 3 clock cycles after the triggering input change, whatever the programmed width. Two synchronizer stages and one output register account for this delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigFallIn | input | 1 | Trigger input that acts on its falling edge (asynchronous) |
| trigRiseIn | input | 1 | Trigger input that acts on its rising edge (asynchronous) |
| clearNIn | input | 1 | Active-low clear; its rising edge can also fire a pulse (asynchronous) |
| widthCfg | input | WIDTH_W | Pulse length in clock cycles (0 is treated as 1) |
| pulseOut | output | 1 | One-shot pulse, active high |
| pulseOutN | output | 1 | Complement of `pulseOut` |

## Verification
A corrupted remaining-count register changes where the falling edge of `pulseOut` lands, so the error appears at the end of the pulse it affects. A stale edge-history register produces a spurious or missing pulse rise exactly 3 cycles after the input change. A lockout counter that loads the wrong value or fails to count down moves the boundary between an ignored trigger and an accepted one. The bench probes both sides of that boundary. Each error therefore shows up within one programmed width, or within one recovery window, of the stimulus that exposes it.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic fire;  // start or restart the interval
    logic kill;  // clear is held: force the pulse low
  } shot_strobe_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int               N       = 3,
  parameter logic [N-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic metaQ, stableQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        metaQ   <= RST_VAL[i];
        stableQ <= RST_VAL[i];
      end else begin
        metaQ   <= asyncIn[i];
        stableQ <= metaQ;
      end
    end
    assign syncOut[i] = stableQ;
  end
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int RECOVER_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fallCur,
  input  logic         riseCur,
  input  logic         clearCur,
  output shot_strobe_t strobe
);
  localparam int LOCK_W = (RECOVER_CYCLES < 1) ? 1 : $clog2(RECOVER_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(RECOVER_CYCLES);

  logic              fallPrev, risePrev, clearPrev;
  logic [LOCK_W-1:0] lockCnt;
  logic              lockActive;
  logic              fallEdge, riseEdge, clearEdge;
  logic              fireFall, fireRise, fireClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallPrev  <= 1'b1;
      risePrev  <= 1'b0;
      clearPrev <= 1'b1;
      lockCnt   <= '0;
    end else begin
      fallPrev  <= fallCur;
      risePrev  <= riseCur;
      clearPrev <= clearCur;
      if (!clearCur)
        lockCnt <= LOCK_LOAD;
      else if (lockActive)
        lockCnt <= lockCnt - 1'b1;
    end
  end

  always_comb begin
    lockActive = (lockCnt != '0);
    fallEdge   = fallPrev & ~fallCur;
    riseEdge   = ~risePrev & riseCur;
    clearEdge  = ~clearPrev & clearCur;
    fireFall   = fallEdge & riseCur & clearCur & ~lockActive;
    fireRise   = riseEdge & ~fallCur & clearCur & ~lockActive;
    fireClear  = clearEdge & ~fallCur & riseCur;
    strobe.fire = fireFall | fireRise | fireClear;
    strobe.kill = ~clearCur;
  end
endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH_W-1:0] widthCfg,
  input  shot_strobe_t       strobe,
  output logic               pulse
);
  logic [WIDTH_W-1:0] remain;
  logic [WIDTH_W-1:0] loadVal;

  // The pulse register carries the first cycle, so load width minus one.
  always_comb loadVal = (widthCfg == '0) ? '0 : widthCfg - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulse  <= 1'b0;
      remain <= '0;
    end else if (strobe.kill) begin
      pulse  <= 1'b0;
      remain <= '0;
    end else if (strobe.fire) begin
      pulse  <= 1'b1;
      remain <= loadVal;
    end else if (pulse) begin
      if (remain == '0)
        pulse <= 1'b0;
      else
        remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W        = 8,
  parameter int RECOVER_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigFallIn,
  input  logic               trigRiseIn,
  input  logic               clearNIn,
  input  logic [WIDTH_W-1:0] widthCfg,
  output logic               pulseOut,
  output logic               pulseOutN
);
  logic [2:0]   syncVec;
  logic         clrCur;
  shot_strobe_t strobe;

  // Bit order {clear, rise, fall}; reset values match the idle levels.
  oneshot_sync #(.N(3), .RST_VAL(3'b101)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({clearNIn, trigRiseIn, trigFallIn}),
    .syncOut(syncVec)
  );

  assign clrCur = syncVec[2];

  oneshot_ctrl #(.RECOVER_CYCLES(RECOVER_CYCLES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fallCur (syncVec[0]),
    .riseCur (syncVec[1]),
    .clearCur(clrCur),
    .strobe  (strobe)
  );

  oneshot_dp #(.WIDTH_W(WIDTH_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .widthCfg(widthCfg),
    .strobe  (strobe),
    .pulse   (pulseOut)
  );

  assign pulseOutN = ~pulseOut;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker
  import oneshot_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         q,
  input logic         qN,
  input logic         clrCur,
  input shot_strobe_t strobe
);
  assert_complement_R11: assert property (@(posedge clk) disable iff (!rstN)
    qN == !q);

  assert_clear_forces_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !clrCur |=> !q);

  assert_fire_sets_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> q);

  assert_no_fire_in_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clrCur |-> !strobe.fire);

  assert_rise_needs_fire_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(q) |-> $past(strobe.fire));
endmodule

bind oneshot_timer oneshot_checker i_checker (
  .clk   (clk),
  .rstN  (rstN),
  .q     (pulseOut),
  .qN    (pulseOutN),
  .clrCur(clrCur),
  .strobe(strobe)
);

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  localparam int WIDTH_W = 8;
  localparam int RECOVER = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               trigFallIn = 1'b1;
  logic               trigRiseIn = 1'b0;
  logic               clearNIn = 1'b1;
  logic [WIDTH_W-1:0] widthCfg = 8'd5;
  logic               pulseOut, pulseOutN;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  typedef struct {
    int    at;
    bit    level;
    string tag;
  } exp_t;
  exp_t sb[$];

  oneshot_timer #(.WIDTH_W(WIDTH_W), .RECOVER_CYCLES(RECOVER)) i_oneshot_timer (
    .clk(clk), .rstN(rstN), .trigFallIn(trigFallIn), .trigRiseIn(trigRiseIn),
    .clearNIn(clearNIn), .widthCfg(widthCfg), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expectAt(input int at, input bit level, input string tag);
    exp_t e;
    e.at = at; e.level = level; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic waitCyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Monitor: pops scoreboard items in the cycle they are due.
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      if (e.at != cyc)
        check(1'b0, {e.tag, " (missed slot)"}, cyc, e.at);
      else begin
        check(pulseOut == e.level, e.tag, int'(pulseOut), int'(e.level));
        check(pulseOutN == !pulseOut, "R11 complement", int'(pulseOutN), int'(!pulseOut));
      end
    end
  end

  initial begin
    int n;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(5);
    check(pulseOut == 1'b0, "R1 reset q", int'(pulseOut), 0);
    check(pulseOutN == 1'b1, "R1 reset qN", int'(pulseOutN), 1);

    // R2: falling edge with the rise input high.
    trigRiseIn = 1'b1;
    waitCyc(3);
    n = cyc;
    expectAt(n + 2, 0, "R12 no early rise");
    expectAt(n + 3, 1, "R2 rise");
    expectAt(n + 7, 1, "R2 last high");
    expectAt(n + 8, 0, "R2 end");
    trigFallIn = 1'b0;
    waitCyc(12);
    trigFallIn = 1'b1; trigRiseIn = 1'b0;
    waitCyc(4);

    // R4: falling edge while the rise input is low is inhibited.
    n = cyc;
    expectAt(n + 3, 0, "R4 inhibit fall");
    expectAt(n + 5, 0, "R4 inhibit fall late");
    trigFallIn = 1'b0;
    waitCyc(8);
    // R4: rising edge while the fall input is high is inhibited.
    trigFallIn = 1'b1;
    waitCyc(4);
    n = cyc;
    expectAt(n + 3, 0, "R4 inhibit rise");
    trigRiseIn = 1'b1;
    waitCyc(8);
    trigRiseIn = 1'b0; trigFallIn = 1'b0;
    waitCyc(4);

    // R3: rising edge with the fall input low.
    n = cyc;
    expectAt(n + 3, 1, "R3 rise");
    expectAt(n + 7, 1, "R3 last high");
    expectAt(n + 8, 0, "R3 end");
    trigRiseIn = 1'b1;
    waitCyc(12);

    // R8: release of clear fires while lockout is loaded.
    clearNIn = 1'b0;
    waitCyc(5);
    n = cyc;
    expectAt(n + 3, 1, "R8 clear-release rise");
    expectAt(n + 8, 0, "R8 clear-release end");
    clearNIn = 1'b1;
    waitCyc(12);
    trigFallIn = 1'b1;
    waitCyc(4);

    // R12: same latency with a long width.
    widthCfg = 8'd20;
    n = cyc;
    expectAt(n + 2, 0, "R12 long width no early");
    expectAt(n + 3, 1, "R12 long width rise");
    expectAt(n + 22, 1, "R12 long width last high");
    expectAt(n + 23, 0, "R12 long width end");
    trigFallIn = 1'b0;
    waitCyc(26);
    trigFallIn = 1'b1;
    waitCyc(4);

    // R10: width 0 acts as 1, and width 1 matches it.
    widthCfg = 8'd0;
    n = cyc;
    expectAt(n + 3, 1, "R10 width0 high");
    expectAt(n + 4, 0, "R10 width0 end");
    trigFallIn = 1'b0;
    waitCyc(8);
    trigFallIn = 1'b1;
    waitCyc(4);
    widthCfg = 8'd1;
    n = cyc;
    expectAt(n + 3, 1, "R10 width1 high");
    expectAt(n + 4, 0, "R10 width1 end");
    trigFallIn = 1'b0;
    waitCyc(8);
    trigFallIn = 1'b1;
    widthCfg = 8'd5;
    waitCyc(4);

    // R5: retrigger in mid-pulse restarts the interval.
    n = cyc;
    expectAt(n + 3, 1, "R5 first rise");
    expectAt(n + 8, 1, "R5 extended past first end");
    expectAt(n + 11, 1, "R5 last high");
    expectAt(n + 12, 0, "R5 end after retrigger");
    trigFallIn = 1'b0;
    waitCyc(2);
    trigFallIn = 1'b1;
    waitCyc(2);
    trigFallIn = 1'b0;
    waitCyc(12);
    trigFallIn = 1'b1;
    waitCyc(4);

    // R6: clear during a pulse cuts it short.
    n = cyc;
    expectAt(n + 3, 1, "R6 pulse started");
    expectAt(n + 6, 1, "R6 still high");
    expectAt(n + 7, 0, "R6 cut by clear");
    trigFallIn = 1'b0;
    waitCyc(4);
    clearNIn = 1'b0;
    waitCyc(4);

    // R7: triggers while clear is low are ignored.
    n = cyc;
    expectAt(n + 3, 0, "R7 ignored fall");
    expectAt(n + 6, 0, "R7 ignored rise");
    expectAt(n + 9, 0, "R7 still low");
    trigFallIn = 1'b1;
    waitCyc(2);
    trigFallIn = 1'b0;
    waitCyc(2);
    trigRiseIn = 1'b0;
    waitCyc(2);
    trigRiseIn = 1'b1;
    waitCyc(4);
    trigFallIn = 1'b1;
    waitCyc(4);

    // R9: lockout after clear release, then acceptance.
    n = cyc;
    clearNIn = 1'b1;
    waitCyc(3);
    n = cyc;
    expectAt(n + 3, 0, "R9 locked fall ignored");
    expectAt(n + 5, 0, "R9 locked fall ignored late");
    trigFallIn = 1'b0;
    waitCyc(6);
    trigFallIn = 1'b1;
    waitCyc(15);
    n = cyc;
    expectAt(n + 3, 1, "R9 accepted after window");
    expectAt(n + 8, 0, "R9 accepted end");
    trigFallIn = 1'b0;
    waitCyc(12);

    while (sb.size() > 0) waitCyc(1);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule